// File: doc/BRIEF.md
# Poly1305 Message Block Limb Expander

This block turns one message block of a Poly1305 authenticator into the five 26-bit limbs that an accumulator adds before it multiplies by the key. A block of up to sixteen bytes arrives as a 128-bit word with a byte count and a valid strobe. The bytes are read as a little-endian integer. Bytes beyond the count are forced to zero. The Poly1305 pad bit is then added, and the result is cut into limbs.

Where the pad bit goes depends on the block length. A full sixteen-byte block gets bit 128 set, which lands in bit 24 of the top limb. A shorter block instead gets a byte of value 0x01 at the byte index equal to its length, and nothing is set above bit 127. Any count outside 1 to 16 is illegal. Such a count is flagged, and it leaves the limb registers untouched.

Top module: `poly_limb_expander`

## Requirements
- R1: After synchronous reset, `out_valid` and `out_err` are 0 and all limb bits are 0. The two outputs are never 1 together.
- R2: An input with `in_valid`=1 and `in_len` from 1 to 16 gives `out_valid`=1 on the cycle after the clock edge that accepts it. `out_valid` is 0 in every other cycle.
- R3: Byte i of `in_data` (bits 8i+7..8i) is weighted 2^(8i). Limb k, for k from 0 to 3, sits in `out_limbs[26k+25:26k]` and holds value bits 26k to 26k+25. Limb 4 sits in `out_limbs[129:104]` and holds value bits 104 to 129.
- R4: When `in_len`=16, the limbs encode the data value plus 2^128. Bit 24 of limb 4 is then 1, and its low 24 bits equal `in_data[127:104]`.
- R5: When `in_len`=L with L from 1 to 15, `in_data` bytes L to 15 have no effect on the output.
- R6: When `in_len`=L with L from 1 to 15, the encoded value is (data mod 2^(8L)) + 2^(8L). Bit 24 of limb 4 is 0.
- R7: When `in_valid`=1 and `in_len` is 0 or greater than 16, `out_err` is 1 on the next cycle, `out_valid` is 0, and `out_limbs` keeps its previous value.
- R8: When `in_valid`=0, `out_limbs` keeps its value and `out_err` is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input block present |
| in_data | input | 128 | Message bytes, byte 0 in bits 7..0 |
| in_len | input | 5 | Number of meaningful bytes (legal 1 to 16) |
| out_valid | output | 1 | Limbs hold a freshly expanded block |
| out_err | output | 1 | The last accepted input carried an illegal length |
| out_limbs | output | 130 | Five 26-bit limbs, limb 0 in the low bits |

## Verification
The bench uses the default configuration: 16-byte blocks, 26-bit limbs and five limbs. With a 5-bit length field, every one of the 32 possible length codes is swept. Each code is combined with directed and pseudo-random data, including all-ones data, which shows any byte that leaks past the stated length. Expected limbs come from plain 130-bit arithmetic in the bench: the data is masked to the length, and 2 raised to eight times the length is added. This checks the split, the two pad rules and the full/partial boundary at length 15 and 16 together. Idle cycles and illegal lengths follow legal blocks, so that holding of the limb registers is seen at the outputs.

// File: rtl/poly_limb_pkg.sv
package poly_limb_pkg;

    localparam int unsigned DEF_BLK_BYTES = 16;
    localparam int unsigned DEF_LIMB_W    = 26;
    localparam int unsigned DEF_N_LIMBS   = 5;

    typedef enum logic [1:0] {
        LEN_BAD  = 2'd0,
        LEN_PART = 2'd1,
        LEN_FULL = 2'd2
    } len_kind_e;

    // Sort a byte count into illegal, partial or full.
    function automatic len_kind_e classify_len(input int unsigned len, input int unsigned blk);
        if (len == 0 || len > blk) return LEN_BAD;
        else if (len == blk)       return LEN_FULL;
        else                       return LEN_PART;
    endfunction

endpackage

// File: rtl/plx_pad.sv
// Zeroes the bytes past the count and drops the 0x01 marker at index len.
// With len equal to the block size no byte is marked.
module plx_pad #(
    parameter int unsigned BYTES = 16,
    parameter int unsigned LW    = 5
) (
    input  logic [BYTES*8-1:0] din,
    input  logic [LW-1:0]      len,
    output logic [BYTES*8-1:0] dout
);
    for (genvar i = 0; i < BYTES; i++) begin : g_byte
        localparam logic [LW-1:0] IDX = LW'(i);
        always_comb begin
            if (IDX < len)       dout[i*8 +: 8] = din[i*8 +: 8];
            else if (IDX == len) dout[i*8 +: 8] = 8'h01;
            else                 dout[i*8 +: 8] = 8'h00;
        end
    end
endmodule

// File: rtl/plx_split.sv
// Cuts the padded block into limbs. The top limb is masked to the
// remaining bits, and then the full-block pad bit is placed just above them.
module plx_split #(
    parameter int unsigned BITS    = 128,
    parameter int unsigned LIMB_W  = 26,
    parameter int unsigned N_LIMBS = 5
) (
    input  logic [BITS-1:0]           padded,
    input  logic                      full,
    output logic [N_LIMBS*LIMB_W-1:0] limbs
);
    localparam int unsigned TOP_W  = BITS - (N_LIMBS - 1) * LIMB_W;
    localparam int unsigned SPARE  = LIMB_W - TOP_W - 1;

    for (genvar k = 0; k < N_LIMBS - 1; k++) begin : g_lo
        assign limbs[k*LIMB_W +: LIMB_W] = padded[k*LIMB_W +: LIMB_W];
    end

    assign limbs[(N_LIMBS-1)*LIMB_W +: LIMB_W] =
        {{SPARE{1'b0}}, full, padded[BITS-1 -: TOP_W]};
endmodule

// File: rtl/poly_limb_expander.sv
module poly_limb_expander
    import poly_limb_pkg::*;
#(
    parameter int unsigned BLK_BYTES = DEF_BLK_BYTES,
    parameter int unsigned LIMB_W    = DEF_LIMB_W,
    parameter int unsigned N_LIMBS   = DEF_N_LIMBS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [BLK_BYTES*8-1:0]        in_data,
    input  logic [$clog2(BLK_BYTES+1)-1:0] in_len,
    output logic                          out_valid,
    output logic                          out_err,
    output logic [N_LIMBS*LIMB_W-1:0]     out_limbs
);
    localparam int unsigned BLK_BITS = BLK_BYTES * 8;
    localparam int unsigned LEN_W    = $clog2(BLK_BYTES + 1);
    localparam int unsigned OUT_W    = N_LIMBS * LIMB_W;

    len_kind_e         kind;
    logic [BLK_BITS-1:0] padded;
    logic [OUT_W-1:0]    limbs_nxt;

    assign kind = classify_len(int'(in_len), BLK_BYTES);

    plx_pad #(.BYTES(BLK_BYTES), .LW(LEN_W)) u_pad (
        .din  (in_data),
        .len  (in_len),
        .dout (padded)
    );

    plx_split #(.BITS(BLK_BITS), .LIMB_W(LIMB_W), .N_LIMBS(N_LIMBS)) u_split (
        .padded (padded),
        .full   (kind == LEN_FULL),
        .limbs  (limbs_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_err   <= 1'b0;
            out_limbs <= '0;
        end else begin
            out_valid <= in_valid && (kind != LEN_BAD);
            out_err   <= in_valid && (kind == LEN_BAD);
            if (in_valid && (kind != LEN_BAD)) out_limbs <= limbs_nxt;
        end
    end

    // R1: flags exclusive
    a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_err));

    // R2: legal input produces valid on the next cycle
    a_r2_valid_next: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_len != '0 && in_len <= LEN_W'(BLK_BYTES)) |=> (out_valid && !out_err));

    // R2: no input, no valid
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R4: full block sets the pad bit above the top data bits
    a_r4_full_pad: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_len == LEN_W'(BLK_BYTES)) |=>
        (out_limbs[(N_LIMBS-1)*LIMB_W + (BLK_BITS - (N_LIMBS-1)*LIMB_W)] &&
         out_limbs[(N_LIMBS-1)*LIMB_W +: (BLK_BITS - (N_LIMBS-1)*LIMB_W)] ==
             $past(in_data[BLK_BITS-1 -: (BLK_BITS - (N_LIMBS-1)*LIMB_W)])));

    // R6: partial block leaves the bit above 127 clear
    a_r6_partial_no_top: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_len != '0 && in_len < LEN_W'(BLK_BYTES)) |=>
        !out_limbs[(N_LIMBS-1)*LIMB_W + (BLK_BITS - (N_LIMBS-1)*LIMB_W)]);

    // R7: illegal length flags and holds
    a_r7_bad_len: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_len == '0 || in_len > LEN_W'(BLK_BYTES))) |=>
        (out_err && !out_valid && $stable(out_limbs)));

    // R8: idle cycle holds the limbs
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_limbs) && !out_err));

endmodule

// File: tb/poly_limb_expander_tb.sv
`timescale 1ns/1ps
module poly_limb_expander_tb;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [127:0] in_data;
    logic [4:0]   in_len;
    logic         out_valid;
    logic         out_err;
    logic [129:0] out_limbs;

    int n_checks = 0;
    int n_fail   = 0;
    logic [129:0] exp_limbs = '0;
    logic [63:0]  rng = 64'h9E37_79B9_7F4A_7C15;

    always #10 clk = ~clk;

    poly_limb_expander u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_len(in_len), .out_valid(out_valid), .out_err(out_err),
        .out_limbs(out_limbs)
    );

    function automatic logic [63:0] step(input logic [63:0] s);
        logic [63:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    function automatic logic [129:0] model(input logic [127:0] d, input int len);
        logic [129:0] m;
        m = (len >= 16) ? {2'b00, {128{1'b1}}} : ((130'd1 << (8*len)) - 130'd1);
        return ({2'b00, d} & m) + (130'd1 << (8*len));
    endfunction

    task automatic chk(input bit ok, input string req, input logic [129:0] act, input logic [129:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [127:0] d, input int len);
        bit legal = (len >= 1 && len <= 16);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_len = 5'(len);
        @(negedge clk);
        in_valid = 1'b0;
        if (legal) exp_limbs = model(d, len);
        chk(out_valid == legal, legal ? "R2" : "R7", 130'(out_valid), 130'(legal));
        chk(out_err == !legal, "R7", 130'(out_err), 130'(!legal));
        if (len == 16)      chk(out_limbs == exp_limbs, "R3 R4", out_limbs, exp_limbs);
        else if (legal)     chk(out_limbs == exp_limbs, "R5 R6", out_limbs, exp_limbs);
        else                chk(out_limbs == exp_limbs, "R7 hold", out_limbs, exp_limbs);
    endtask

    initial begin
        #(20.0 * 200000);
        n_fail++; n_checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_data = '0; in_len = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!out_valid && !out_err && out_limbs == '0, "R1", out_limbs, '0);

        // R3: directed byte weights
        apply(128'h01, 16);
        chk(out_limbs[25:0] == 26'd1, "R3 limb0", {104'd0, out_limbs[25:0]}, 130'd1);
        apply(128'h1 << 104, 16);
        chk(out_limbs[129:104] == 26'h1000001, "R3 R4 limb4", {104'd0, out_limbs[129:104]}, 130'h1000001);
        apply('1, 15);
        chk(out_limbs[129:104] == 26'h0010000 + 26'h00FFFF, "R6 limb4", {104'd0, out_limbs[129:104]}, 130'h001FFFF);

        for (int p = 0; p < 12; p++) begin
            for (int l = 0; l < 32; l++) begin
                logic [127:0] d;
                case (p)
                    0: d = '0;
                    1: d = '1;
                    2: d = {16{8'hA5}};
                    3: d = {16{8'h5A}};
                    default: begin
                        rng = step(rng); d[63:0] = rng;
                        rng = step(rng); d[127:64] = rng;
                    end
                endcase
                apply(d, l);
                if (l % 5 == 0) begin
                    @(negedge clk);
                    chk(out_limbs == exp_limbs && !out_valid && !out_err, "R8 idle",
                        out_limbs, exp_limbs);
                end
            end
        end

        // R5: stray bytes above the count do not matter
        for (int l = 1; l < 16; l++) begin
            logic [129:0] first;
            apply('0, l);
            first = out_limbs;
            apply('1 << (8*l), l);
            chk(out_limbs == first, "R5 stray", out_limbs, first);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule